// File: doc/BRIEF.md
# Clock Source Mode Sequencer

This block selects which of six clock-generation modes drives the chip. A mode is a combination of three choices: whether the frequency-locked loop (FLL) output is used or bypassed, whether the reference is internal or external, and, for the two bypassed modes only, a low-power variant in which the FLL is also switched off. Software presents a requested mode code with a one-cycle valid strobe. The block checks the request against the permitted transitions and either moves to the new mode or keeps the current one and raises a one-cycle error flag.

From the current mode the block drives the FLL enable, the bypass select, the reference select and the external-reference enable. The external-reference enable can be kept on during stop when a keep bit asks for it. It also reports the mode code and a permission flag for the power-mode controller, which is high only in the external low-power bypass mode. The clocks themselves are modelled as enables and selects.

A bus divider runs in every mode. It issues a one-cycle bus tick every 1, 2, 4 or 8 cycles, as set by a 2-bit field. A new setting is adopted only at a divided-clock boundary, so a tick interval is never cut short. Changing the divider never touches the mode or the FLL controls.

Top module: `clkseq_top`

## Requirements
- R1: Mode codes are 0 = FLL used, internal reference; 1 = FLL used, external reference; 2 = bypassed, internal; 3 = bypassed, external; 4 = low-power bypassed, internal; 5 = low-power bypassed, external. `fll_bypass_o` is 1 for codes 2 to 5, and `ref_ext_sel_o` is 1 for codes 1, 3 and 5.
- R2: During and after synchronous reset the mode is 0, `fll_en_o` = 1, `fll_bypass_o` = 0, `ref_ext_sel_o` = 0, `req_err_o` = 0, and the divider ratio is 1, so `bus_tick_o` is high every cycle.
- R3: A request that is not permitted, including codes 6 and 7, leaves the mode unchanged and sets `req_err_o` high for exactly the cycle after the request.
- R4: Code 4 is accepted only while the current mode is 2, and code 5 only while the current mode is 3.
- R5: A request for any of codes 0 to 3 is accepted from any mode. An accepted request takes effect on `mode_o` in the cycle after the strobe. A request for the current mode is accepted and changes nothing.
- R6: `fll_en_o` is 0 in modes 4 and 5 and 1 in modes 0 to 3.
- R7: From one low-power mode, a request for the other low-power mode is rejected, and a request for any of codes 0 to 3 is accepted.
- R8: With divider field value d (0 to 3), `bus_tick_o` is high for one cycle in every 2^d cycles, in every mode, and mode changes do not alter the spacing.
- R9: A new divider value is adopted only in the cycle after a tick. The interval that follows that tick uses the new ratio, and an interval already under way completes at its old length.
- R10: `ext_ref_en_o` is 1 when the mode uses the external reference (codes 1, 3, 5) and either `stop_i` is 0 or `stop_keep_ext_i` is 1; otherwise it is 0.
- R11: `lp_run_ok_o` is 1 exactly when the mode is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | One-cycle strobe for a mode request |
| req_mode_i | input | 3 | Requested mode code |
| div_sel_i | input | DIV_W (2) | Bus divider setting, divide by 2^value |
| stop_i | input | 1 | Chip is in a stop state |
| stop_keep_ext_i | input | 1 | Keep the external reference on during stop |
| fll_en_o | output | 1 | FLL enable |
| fll_bypass_o | output | 1 | Output taken from the reference, not the FLL |
| ref_ext_sel_o | output | 1 | External reference selected |
| ext_ref_en_o | output | 1 | External reference source enable |
| mode_o | output | 3 | Current mode code |
| lp_run_ok_o | output | 1 | Low-power run permitted (mode 5) |
| req_err_o | output | 1 | Previous-cycle request was rejected |
| bus_tick_o | output | 1 | One-cycle divided bus clock tick |

## Verification
The in-line assertions check on every cycle that a rejected request left the mode unchanged, that each low-power mode was entered only from its parent bypass mode, that the FLL is off in both low-power modes, that the low-power permission implies an external bypassed source with the FLL off, and that the divider ratio register moves only at a tick boundary. Only the bench's scenarios can show the mapping from each requested code to the exact resulting mode, the precise tick spacing before and after a divider change, and the stop-time gating of the external reference, because these are compared cycle by cycle against an independent model under random and directed requests.

// File: rtl/clkseq_pkg.sv
// Package: mode codes, the control bundle driven per mode, and helpers.
// Assumes a 3-bit mode code; codes 6 and 7 are never a legal mode.
package clkseq_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_LOOP_INT = 3'd0;
    localparam logic [MODE_W-1:0] MODE_LOOP_EXT = 3'd1;
    localparam logic [MODE_W-1:0] MODE_BYP_INT  = 3'd2;
    localparam logic [MODE_W-1:0] MODE_BYP_EXT  = 3'd3;
    localparam logic [MODE_W-1:0] MODE_LPB_INT  = 3'd4;
    localparam logic [MODE_W-1:0] MODE_LPB_EXT  = 3'd5;
    localparam logic [MODE_W-1:0] MODE_LAST     = MODE_LPB_EXT;

    // Control bundle that the decoder derives from the current mode.
    typedef struct packed {
        logic fll_en;
        logic bypass;
        logic ext_sel;
    } src_ctrl_t;

    // True for the two low-power bypassed modes.
    function automatic logic is_low_power(input logic [MODE_W-1:0] m);
        return (m == MODE_LPB_INT) || (m == MODE_LPB_EXT);
    endfunction

    // Parent bypass mode from which a low-power mode may be entered.
    function automatic logic [MODE_W-1:0] lp_parent(input logic [MODE_W-1:0] m);
        return (m == MODE_LPB_INT) ? MODE_BYP_INT : MODE_BYP_EXT;
    endfunction

endpackage

// File: rtl/clkseq_policy.sv
// Transition policy: decides whether a requested mode may follow the
// current one. Purely combinational; assumes cur_mode is always a legal code.
module clkseq_policy
    import clkseq_pkg::*;
(
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] tgt_mode,
    output logic              accept
);

    logic tgt_known;
    logic tgt_lp;

    // Classify the target code.
    always_comb begin
        tgt_known = (tgt_mode <= MODE_LAST);
        tgt_lp    = is_low_power(tgt_mode);
    end

    // Grant rule: unknown codes never; same mode always; low-power only from its parent.
    always_comb begin
        if (!tgt_known)
            accept = 1'b0;
        else if (tgt_mode == cur_mode)
            accept = 1'b1;
        else if (tgt_lp)
            accept = (cur_mode == lp_parent(tgt_mode));
        else
            accept = 1'b1;
    end

endmodule

// File: rtl/clkseq_decode.sv
// Source decoder: turns the current mode into FLL, bypass and reference
// controls, applies the stop-time keep rule to the external reference and
// derives the low-power-run permission. Combinational; mode is a legal code.
module clkseq_decode
    import clkseq_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              stop,
    input  logic              stop_keep_ext,
    output src_ctrl_t         ctrl,
    output logic              ext_ref_en,
    output logic              lp_run_ok
);

    // Per-mode control table.
    always_comb begin
        unique case (mode)
            MODE_LOOP_INT: ctrl = '{fll_en: 1'b1, bypass: 1'b0, ext_sel: 1'b0};
            MODE_LOOP_EXT: ctrl = '{fll_en: 1'b1, bypass: 1'b0, ext_sel: 1'b1};
            MODE_BYP_INT:  ctrl = '{fll_en: 1'b1, bypass: 1'b1, ext_sel: 1'b0};
            MODE_BYP_EXT:  ctrl = '{fll_en: 1'b1, bypass: 1'b1, ext_sel: 1'b1};
            MODE_LPB_INT:  ctrl = '{fll_en: 1'b0, bypass: 1'b1, ext_sel: 1'b0};
            MODE_LPB_EXT:  ctrl = '{fll_en: 1'b0, bypass: 1'b1, ext_sel: 1'b1};
            default:       ctrl = '{fll_en: 1'b1, bypass: 1'b0, ext_sel: 1'b0};
        endcase
    end

    // External source stays on while in use, unless stopped without the keep bit.
    always_comb begin
        ext_ref_en = ctrl.ext_sel && (!stop || stop_keep_ext);
        lp_run_ok  = (mode == MODE_LPB_EXT);
    end

endmodule

// File: rtl/clkseq_busdiv.sv
// Bus divider: emits a one-cycle tick every 2^ratio cycles. A new setting
// is captured only in the cycle after a tick so no interval is shortened.
// Assumes div_sel is a plain binary exponent, 0 meaning divide by one.
module clkseq_busdiv #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] ratio_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count per ratio: bit b set when b is below the exponent.
    for (genvar b = 0; b < CNT_W; b++) begin : g_limit
        assign limit[b] = (b < int'(ratio_q));
    end

    // Tick on the terminal count of the active ratio.
    always_comb tick = (cnt_q == limit);

    // Count, wrap at the boundary and adopt the pending setting there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= '0;
        end else if (tick) begin
            cnt_q   <= '0;
            ratio_q <= div_sel;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R9: the active ratio never moves except right after a tick.
    a_r9_ratio_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ratio_q));

    // R8: the counter never runs past the active terminal count.
    a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

endmodule

// File: rtl/clkseq_top.sv
// Clock source mode sequencer top: holds the current mode, grants or
// rejects requests through the policy, decodes source controls and runs
// the bus divider independently of the mode. Synchronous active-low reset.
module clkseq_top
    import clkseq_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [2:0]       req_mode_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             stop_i,
    input  logic             stop_keep_ext_i,
    output logic             fll_en_o,
    output logic             fll_bypass_o,
    output logic             ref_ext_sel_o,
    output logic             ext_ref_en_o,
    output logic [2:0]       mode_o,
    output logic             lp_run_ok_o,
    output logic             req_err_o,
    output logic             bus_tick_o
);

    logic [MODE_W-1:0] mode_q;
    logic              err_q;
    logic              grant;
    src_ctrl_t         ctrl;

    clkseq_policy i_policy (
        .cur_mode (mode_q),
        .tgt_mode (req_mode_i),
        .accept   (grant)
    );

    // Mode register and reject flag update on each request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LOOP_INT;
            err_q  <= 1'b0;
        end else begin
            err_q <= req_valid_i && !grant;
            if (req_valid_i && grant)
                mode_q <= req_mode_i;
        end
    end

    clkseq_decode i_decode (
        .mode          (mode_q),
        .stop          (stop_i),
        .stop_keep_ext (stop_keep_ext_i),
        .ctrl          (ctrl),
        .ext_ref_en    (ext_ref_en_o),
        .lp_run_ok     (lp_run_ok_o)
    );

    clkseq_busdiv #(.DIV_W(DIV_W)) i_busdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel_i),
        .tick    (bus_tick_o)
    );

    // Drive the outputs from the registered mode and the decoded bundle.
    always_comb begin
        mode_o        = mode_q;
        req_err_o     = err_q;
        fll_en_o      = ctrl.fll_en;
        fll_bypass_o  = ctrl.bypass;
        ref_ext_sel_o = ctrl.ext_sel;
    end

    // R1: the mode register only ever holds one of the six codes.
    a_r1_mode_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q <= MODE_LAST);

    // R3: a reported rejection means the mode did not move.
    a_r3_reject_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
        req_err_o |-> (mode_q == $past(mode_q)));

    // R4: internal low-power mode is entered only from internal bypass.
    a_r4_lp_int_parent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LPB_INT && $past(mode_q) != MODE_LPB_INT)
            |-> ($past(mode_q) == MODE_BYP_INT));

    // R4: external low-power mode is entered only from external bypass.
    a_r4_lp_ext_parent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LPB_EXT && $past(mode_q) != MODE_LPB_EXT)
            |-> ($past(mode_q) == MODE_BYP_EXT));

    // R6: the FLL is off in both low-power modes.
    a_r6_lp_fll_off: assert property (@(posedge clk) disable iff (!rst_n)
        is_low_power(mode_q) |-> !fll_en_o);

    // R11: permission implies an external bypassed source with the FLL off.
    a_r11_lprun_source: assert property (@(posedge clk) disable iff (!rst_n)
        lp_run_ok_o |-> (fll_bypass_o && ref_ext_sel_o && !fll_en_o));

endmodule

// File: tb/test_clkseq_top.sv
module test_clkseq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid_i = 1'b0;
    logic [2:0] req_mode_i = 3'd0;
    logic [1:0] div_sel_i = 2'd0;
    logic       stop_i = 1'b0;
    logic       stop_keep_ext_i = 1'b0;
    logic       fll_en_o, fll_bypass_o, ref_ext_sel_o, ext_ref_en_o;
    logic [2:0] mode_o;
    logic       lp_run_ok_o, req_err_o, bus_tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int em = 0;      // expected mode
    int eerr = 0;    // expected reject flag
    int ecnt = 0;    // expected divider position
    int eratio = 0;  // expected active exponent

    always #10 clk = ~clk;

    clkseq_top i_clkseq_top (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_mode_i(req_mode_i),
        .div_sel_i(div_sel_i), .stop_i(stop_i), .stop_keep_ext_i(stop_keep_ext_i),
        .fll_en_o(fll_en_o), .fll_bypass_o(fll_bypass_o), .ref_ext_sel_o(ref_ext_sel_o),
        .ext_ref_en_o(ext_ref_en_o), .mode_o(mode_o), .lp_run_ok_o(lp_run_ok_o),
        .req_err_o(req_err_o), .bus_tick_o(bus_tick_o)
    );

    function automatic bit legal(int cur, int tgt);
        if (tgt > 5) return 0;
        if (tgt == cur) return 1;
        if (tgt == 4) return cur == 2;
        if (tgt == 5) return cur == 3;
        return 1;
    endfunction
    function automatic int x_byp(int m); return (m >= 2 && m <= 5) ? 1 : 0; endfunction
    function automatic int x_ext(int m); return (m == 1 || m == 3 || m == 5) ? 1 : 0; endfunction
    function automatic int x_fll(int m); return (m < 4) ? 1 : 0; endfunction
    function automatic int x_tick(); return (ecnt == (1 << eratio) - 1) ? 1 : 0; endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model (called at a falling edge).
    task automatic check_all();
        check("R5 mode", int'(mode_o), em);
        check("R3 req_err", int'(req_err_o), eerr);
        check("R6 fll_en", int'(fll_en_o), x_fll(em));
        check("R1 bypass", int'(fll_bypass_o), x_byp(em));
        check("R1 ext_sel", int'(ref_ext_sel_o), x_ext(em));
        check("R10 ext_ref_en", int'(ext_ref_en_o),
              (x_ext(em) == 1 && (!stop_i || stop_keep_ext_i)) ? 1 : 0);
        check("R11 lp_run_ok", int'(lp_run_ok_o), (em == 5) ? 1 : 0);
        check("R8/R9 bus_tick", int'(bus_tick_o), x_tick());
    endtask

    // Apply inputs, advance the model over one rising edge, then check.
    task automatic step(bit v, int m, int d, bit st, bit kp);
        req_valid_i = v; req_mode_i = 3'(m); div_sel_i = 2'(d);
        stop_i = st; stop_keep_ext_i = kp;
        eerr = (v && !legal(em, m)) ? 1 : 0;
        if (v && legal(em, m)) em = m;
        if (x_tick() == 1) begin ecnt = 0; eratio = d; end
        else ecnt++;
        @(negedge clk);
        check_all();
    endtask

    int cur_div = 0;

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        // R2: reset state
        check("R2 reset mode", int'(mode_o), 0);
        check("R2 reset fll_en", int'(fll_en_o), 1);
        check("R2 reset bypass", int'(fll_bypass_o), 0);
        check("R2 reset ext_sel", int'(ref_ext_sel_o), 0);
        check("R2 reset req_err", int'(req_err_o), 0);
        check("R2 reset tick", int'(bus_tick_o), 1);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0);
        check("R2 divide by one after reset", int'(bus_tick_o), 1);

        // R4: skipping the parent is rejected
        step(1, 4, 0, 0, 0);
        check("R4 skip parent rejected", int'(req_err_o), 1);
        check("R4 mode kept", int'(mode_o), 0);
        step(1, 2, 0, 0, 0);
        step(1, 4, 0, 0, 0);
        check("R4 entry from parent", int'(mode_o), 4);
        check("R6 fll off in low power", int'(fll_en_o), 0);
        // R7: low-power to other low-power rejected, then exit
        step(1, 5, 0, 0, 0);
        check("R7 cross low-power rejected", int'(req_err_o), 1);
        check("R7 mode kept", int'(mode_o), 4);
        step(1, 1, 0, 0, 0);
        check("R7 exit to loop external", int'(mode_o), 1);
        // R3: unknown code
        step(1, 7, 0, 0, 0);
        check("R3 code 7 rejected", int'(req_err_o), 1);
        step(0, 0, 0, 0, 0);
        check("R3 flag lasts one cycle", int'(req_err_o), 0);
        // R11 and R10
        step(1, 3, 0, 0, 0);
        step(1, 5, 0, 0, 0);
        check("R11 permission in mode 5", int'(lp_run_ok_o), 1);
        step(0, 0, 0, 1, 0);
        check("R10 stop drops external", int'(ext_ref_en_o), 0);
        step(0, 0, 0, 1, 1);
        check("R10 keep bit holds external", int'(ext_ref_en_o), 1);
        // R9: divider change while in low-power mode
        step(0, 0, 3, 0, 0);
        for (int i = 0; i < 20; i++) step(0, 0, 3, 0, 0);
        step(0, 0, 1, 0, 0);
        for (int i = 0; i < 12; i++) step(1, 5, 1, 0, 0);
        cur_div = 1;

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int r, m;
            bit v;
            r = int'($urandom_range(99));
            v = (r < 50);
            r = int'($urandom_range(99));
            if (r < 90) m = int'($urandom_range(5)); else m = 6 + int'($urandom_range(1));
            if ($urandom_range(99) < 5) cur_div = int'($urandom_range(3));
            step(v, m, cur_div, ($urandom_range(99) < 20), $urandom_range(1) == 1);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule